// File: doc/BRIEF.md
# Interrupt destination mask resolver

This block takes one interrupt request and works out which targets it reaches. A target is one of a fixed number of interrupt receivers. The request carries a destination byte, a bit choosing physical or logical addressing, a two-bit shorthand, a three-bit delivery-mode code, level and trigger bits, and the index of the requesting target. Every target supplies four pieces of configuration: a present flag, an ID byte, a logical destination byte and a four-bit destination model. From these the block builds a per-target selection vector. One clock after the request is valid it presents that vector as a delivery mask, together with a one-cycle done strobe.

Two delivery modes change the result. Lowest-priority delivery keeps only the lowest-indexed selected target. An INIT de-assert request (INIT with level 0 and trigger 1) delivers to no one. Instead, each selected target's arbitration ID register is loaded from that target's ID. The block holds these registers and exposes them. Injecting the interrupt and arbitrating by priority are left to the logic that consumes the mask.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 (self) selects only the target whose index equals `req_src`.
- R2: Shorthand code 2 (all) selects every target.
- R3: Shorthand code 3 (others) selects every target except the one whose index equals `req_src`.
- R4: With shorthand 0 and `req_logical` = 0, destination 0xFF selects every target. Any other destination selects each target whose ID equals it, and otherwise none.
- R5: With shorthand 0 and `req_logical` = 1, a target whose model is 0xF is selected when the destination ANDed with its logical destination is nonzero.
- R6: With shorthand 0 and `req_logical` = 1, a target whose model is 0x0 is selected when the upper nibbles of the destination and its logical destination are equal and the lower nibbles share a set bit. A target with any other model value is not selected.
- R7: Delivery mode code 1 (lowest priority) reduces the mask to its lowest-indexed set bit.
- R8: Delivery mode code 5 (INIT) with `req_level` = 0 and `req_trigger` = 1 yields an empty mask. It loads each selected target's ID into that target's arbitration ID. No other request and no idle cycle changes any arbitration ID.
- R9: A target whose present bit is 0 is never selected, whatever the shorthand or broadcast rule.
- R10: `done` is high exactly in the cycle after a cycle with `req_valid` high. `dlv_mask` is zero whenever `done` is low.
- R11: The reserved delivery mode codes 3 and 7 yield an empty mask. The codes 0, 2, 4, 6 and INIT other than de-assert deliver the selection unchanged.
- R12: After reset, `done` is 0, `dlv_mask` is 0 and every arbitration ID is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request fields are valid this cycle |
| req_dest | input | DEST_W | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 destination, 1 self, 2 all, 3 others |
| req_dmode | input | 3 | Delivery mode code |
| req_level | input | 1 | Level bit of the request |
| req_trigger | input | 1 | Trigger bit of the request |
| req_src | input | SRC_W | Index of the requesting target |
| tgt_present | input | NUM_TGT | Present flag per target |
| tgt_id | input | NUM_TGT*DEST_W | Target IDs, target i at bits i*DEST_W upward |
| tgt_ldest | input | NUM_TGT*DEST_W | Logical destinations, packed like tgt_id |
| tgt_model | input | NUM_TGT*4 | Destination model per target |
| done | output | 1 | Result strobe, one cycle after a valid request |
| dlv_mask | output | NUM_TGT | Delivery mask, bit i for target i |
| arb_id | output | NUM_TGT*DEST_W | Arbitration ID per target, packed like tgt_id |

## Verification
A wrong per-target match term shows up as one wrong bit in `dlv_mask`. It appears on the done strobe of the very request that exercises that target's mode and model. A faulty lowest-pick shows up as extra or wrong bits on any lowest-priority request whose selection has two or more hits. A wrong arbitration-ID load can stay silent at `dlv_mask`, so `arb_id` is compared after every request. That way an update that is missing or happens when it should not is seen in the same cycle as the strobe. Sweeping every shorthand, mode, source and delivery code over spread destination values and two target tables reaches each of these paths.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

   typedef enum logic [2:0] {
      DM_FIXED  = 3'd0,
      DM_LOWEST = 3'd1,
      DM_SMI    = 3'd2,
      DM_RSV3   = 3'd3,
      DM_NMI    = 3'd4,
      DM_INIT   = 3'd5,
      DM_START  = 3'd6,
      DM_RSV7   = 3'd7
   } dmode_e;

   typedef enum logic [1:0] {
      SH_DEST   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   localparam int         MODEL_W       = 4;
   localparam logic [3:0] MODEL_FLAT    = 4'hF;
   localparam logic [3:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/irq_tgt_match.sv
// Address match of one target against the destination field.
module irq_tgt_match
   import irq_dest_pkg::*;
#(
   parameter int DEST_W = 8,
   localparam int HALF  = DEST_W / 2
) (
   input  logic [DEST_W-1:0]  dest,
   input  logic               logical,
   input  logic [DEST_W-1:0]  id,
   input  logic [DEST_W-1:0]  ldest,
   input  logic [MODEL_W-1:0] model,
   output logic               hit
);

   logic bcast, phys_hit, flat_hit, clus_hit;

   always_comb begin
      bcast    = &dest;
      phys_hit = bcast || (dest == id);
      flat_hit = (model == MODEL_FLAT) && (|(dest & ldest));
      clus_hit = (model == MODEL_CLUSTER)
               && (dest[DEST_W-1:HALF] == ldest[DEST_W-1:HALF])
               && (|(dest[HALF-1:0] & ldest[HALF-1:0]));
      hit      = logical ? (flat_hit || clus_hit) : phys_hit;
   end

endmodule

// File: rtl/irq_lowest_pick.sv
// Keeps the lowest-indexed set bit of a vector.
module irq_lowest_pick #(
   parameter int N     = 8,
   parameter bit ARITH = 1'b0
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   generate
      if (ARITH) begin : g_arith
         assign grant = req & (~req + N'(1));
      end else begin : g_scan
         always_comb begin
            logic found;
            found = 1'b0;
            grant = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !found) begin
                  grant[i] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_arb_bank.sv
// Per-target arbitration ID registers.
module irq_arb_bank #(
   parameter int N      = 8,
   parameter int DEST_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        load,
   input  logic [N*DEST_W-1:0] id_in,
   output logic [N*DEST_W-1:0] arb_out
);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_reg
         logic [DEST_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        val_q <= '0;
            else if (load[gi]) val_q <= id_in[gi*DEST_W +: DEST_W];
         end
         assign arb_out[gi*DEST_W +: DEST_W] = val_q;
      end
   endgenerate

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int NUM_TGT    = 8,
   parameter int DEST_W     = 8,
   parameter bit PICK_ARITH = 1'b0,
   localparam int SRC_W     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [DEST_W-1:0]         req_dest,
   input  logic                      req_logical,
   input  logic [1:0]                req_shorthand,
   input  logic [2:0]                req_dmode,
   input  logic                      req_level,
   input  logic                      req_trigger,
   input  logic [SRC_W-1:0]          req_src,
   input  logic [NUM_TGT-1:0]        tgt_present,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_id,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_ldest,
   input  logic [NUM_TGT*MODEL_W-1:0] tgt_model,
   output logic                      done,
   output logic [NUM_TGT-1:0]        dlv_mask,
   output logic [NUM_TGT*DEST_W-1:0] arb_id
);

   generate
      if (NUM_TGT < 1 || NUM_TGT > 32) begin : g_bad_count
         $error("NUM_TGT must lie in 1..32");
      end
      if (DEST_W < 2 || (DEST_W % 2) != 0) begin : g_bad_width
         $error("DEST_W must be even and at least 2");
      end
   endgenerate

   dmode_e     dm;
   shorthand_e sh;
   logic       init_deassert, reserved_mode;

   logic [NUM_TGT-1:0] addr_hit, scope_sel, sel, lowest, deliver_nx, arb_load;
   logic               done_q;
   logic [NUM_TGT-1:0] mask_q;

   assign dm = dmode_e'(req_dmode);
   assign sh = shorthand_e'(req_shorthand);
   assign init_deassert = (dm == DM_INIT) && !req_level && req_trigger;
   assign reserved_mode = (dm == DM_RSV3) || (dm == DM_RSV7);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_TGT; gi++) begin : g_tgt
         logic sc;
         irq_tgt_match #(.DEST_W(DEST_W)) u_match (
            .dest    (req_dest),
            .logical (req_logical),
            .id      (tgt_id[gi*DEST_W +: DEST_W]),
            .ldest   (tgt_ldest[gi*DEST_W +: DEST_W]),
            .model   (tgt_model[gi*MODEL_W +: MODEL_W]),
            .hit     (addr_hit[gi])
         );
         always_comb begin
            unique case (sh)
               SH_DEST:   sc = addr_hit[gi];
               SH_SELF:   sc = (req_src == SRC_W'(gi));
               SH_ALL:    sc = 1'b1;
               SH_OTHERS: sc = (req_src != SRC_W'(gi));
               default:   sc = 1'b0;
            endcase
         end
         assign scope_sel[gi] = sc;
      end
   endgenerate

   assign sel = scope_sel & tgt_present;

   irq_lowest_pick #(.N(NUM_TGT), .ARITH(PICK_ARITH)) u_pick (
      .req   (sel),
      .grant (lowest)
   );

   always_comb begin
      if (init_deassert || reserved_mode) deliver_nx = '0;
      else if (dm == DM_LOWEST)           deliver_nx = lowest;
      else                                deliver_nx = sel;
   end

   assign arb_load = (req_valid && init_deassert) ? sel : '0;

   irq_arb_bank #(.N(NUM_TGT), .DEST_W(DEST_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (arb_load),
      .id_in   (tgt_id),
      .arb_out (arb_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         mask_q <= '0;
      end else begin
         done_q <= req_valid;
         mask_q <= req_valid ? deliver_nx : '0;
      end
   end

   assign done     = done_q;
   assign dlv_mask = mask_q;

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8,
   parameter int SRC_W   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic [2:0]                req_dmode,
   input logic                      req_level,
   input logic                      req_trigger,
   input logic [NUM_TGT-1:0]        tgt_present,
   input logic                      done,
   input logic [NUM_TGT-1:0]        dlv_mask,
   input logic [NUM_TGT*DEST_W-1:0] arb_id
);

   logic init_da;
   assign init_da = req_valid && (req_dmode == 3'd5) && !req_level && req_trigger;

   assert_done_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid));

   assert_idle_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (dlv_mask == '0));

   assert_present_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((dlv_mask & ~$past(tgt_present)) == '0));

   assert_lowest_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(req_dmode) == 3'd1) |-> ($countones(dlv_mask) <= 1));

   assert_init_deassert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_da) |-> (dlv_mask == '0));

   assert_arb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(init_da) |-> $stable(arb_id));

   assert_reserved_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid) && ($past(req_dmode) == 3'd3 || $past(req_dmode) == 3'd7))
      |-> (dlv_mask == '0));

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
   .NUM_TGT (NUM_TGT),
   .DEST_W  (DEST_W),
   .SRC_W   (SRC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_dmode   (req_dmode),
   .req_level   (req_level),
   .req_trigger (req_trigger),
   .tgt_present (tgt_present),
   .done        (done),
   .dlv_mask    (dlv_mask),
   .arb_id      (arb_id)
);

// File: tb/sim_irq_dest_resolver.sv
`timescale 1ns/1ps
module sim_irq_dest_resolver;

   localparam int N  = 4;
   localparam int DW = 8;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [DW-1:0] req_dest = '0;
   logic          req_logical = 1'b0;
   logic [1:0]    req_shorthand = '0;
   logic [2:0]    req_dmode = '0;
   logic          req_level = 1'b0;
   logic          req_trigger = 1'b0;
   logic [SW-1:0] req_src = '0;
   logic [N-1:0]  tgt_present = '0;
   logic [N*DW-1:0] tgt_id = '0;
   logic [N*DW-1:0] tgt_ldest = '0;
   logic [N*4-1:0]  tgt_model = '0;
   logic          done;
   logic [N-1:0]  dlv_mask;
   logic [N*DW-1:0] arb_id;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] c_id [N];
   logic [7:0] c_ld [N];
   logic [3:0] c_md [N];
   logic [N-1:0] c_pr;
   logic [7:0] exp_arb [N];

   always #4 clk = ~clk;

   irq_dest_resolver #(.NUM_TGT(N), .DEST_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
      .req_logical(req_logical), .req_shorthand(req_shorthand),
      .req_dmode(req_dmode), .req_level(req_level), .req_trigger(req_trigger),
      .req_src(req_src), .tgt_present(tgt_present), .tgt_id(tgt_id),
      .tgt_ldest(tgt_ldest), .tgt_model(tgt_model), .done(done),
      .dlv_mask(dlv_mask), .arb_id(arb_id)
   );

   function automatic logic [N*DW-1:0] arb_flat();
      logic [N*DW-1:0] r;
      for (int i = 0; i < N; i++) r[i*DW +: DW] = exp_arb[i];
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic load_cfg();
      for (int i = 0; i < N; i++) begin
         tgt_id[i*DW +: DW]    = c_id[i];
         tgt_ldest[i*DW +: DW] = c_ld[i];
         tgt_model[i*4 +: 4]   = c_md[i];
      end
      tgt_present = c_pr;
   endtask

   function automatic logic [N-1:0] calc_sel(int sh, int lg, logic [7:0] d, int src);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         logic h;
         case (sh)
            0: begin
               if (lg != 0) begin
                  if (c_md[i] == 4'hF)      h = (d & c_ld[i]) != 0;
                  else if (c_md[i] == 4'h0) h = (d[7:4] == c_ld[i][7:4]) && ((d[3:0] & c_ld[i][3:0]) != 0);
                  else                      h = 1'b0;
               end else begin
                  h = (d == 8'hFF) || (d == c_id[i]);
               end
            end
            1: h = (i == src);
            2: h = 1'b1;
            default: h = (i != src);
         endcase
         r[i] = h & c_pr[i];
      end
      return r;
   endfunction

   function automatic string tag_of(int sh, int lg, int dm, int lvl, int trg);
      if (dm == 5 && lvl == 0 && trg == 1) return "R8 R9";
      if (dm == 3 || dm == 7)              return "R11";
      if (dm == 1)                         return "R7 R9";
      if (sh == 1) return "R1 R9";
      if (sh == 2) return "R2 R9";
      if (sh == 3) return "R3 R9";
      if (lg == 0) return "R4 R9";
      return "R5 R6 R9";
   endfunction

   task automatic run_req(input int sh, input int lg, input int dm, input int src,
                          input logic [7:0] d, input int lvl, input int trg);
      logic [N-1:0] sel, expm;
      @(negedge clk);
      check(!done && dlv_mask == '0, "R10 idle", {done, dlv_mask}, '0);
      req_valid = 1'b1; req_dest = d; req_logical = lg[0];
      req_shorthand = sh[1:0]; req_dmode = dm[2:0];
      req_level = lvl[0]; req_trigger = trg[0]; req_src = src[SW-1:0];
      sel = calc_sel(sh, lg, d, src);
      if (dm == 5 && lvl == 0 && trg == 1) begin
         expm = '0;
         for (int i = 0; i < N; i++) if (sel[i]) exp_arb[i] = c_id[i];
      end else if (dm == 3 || dm == 7) begin
         expm = '0;
      end else if (dm == 1) begin
         expm = sel & (~sel + 1'b1);
      end else begin
         expm = sel;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check(done == 1'b1, "R10 strobe", done, 1);
      check(dlv_mask == expm, tag_of(sh, lg, dm, lvl, trg), dlv_mask, expm);
      check(arb_id == arb_flat(), "R8 arbitration", arb_id, arb_flat());
   endtask

   task automatic sweep();
      load_cfg();
      for (int k = 0; k < 38; k++) begin
         logic [7:0] d;
         d = (k == 37) ? 8'hFF : 8'(k * 7);
         for (int sh = 0; sh < 4; sh++)
            for (int lg = 0; lg < 2; lg++)
               for (int dm = 0; dm < 8; dm++)
                  for (int src = 0; src < N; src++)
                     run_req(sh, lg, dm, src, d, int'(d[0]), int'(d[1]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) exp_arb[i] = '0;
      repeat (3) @(negedge clk);
      // R12: reset state
      check(done == 1'b0 && dlv_mask == '0, "R12 outputs", {done, dlv_mask}, '0);
      check(arb_id == '0, "R12 arbitration", arb_id, '0);
      rst_n = 1'b1;

      // table A: target 2 absent, target 3 has a model matching neither rule
      c_id[0] = 8'h02; c_id[1] = 8'h07; c_id[2] = 8'h15; c_id[3] = 8'h23;
      c_ld[0] = 8'h01; c_ld[1] = 8'h16; c_ld[2] = 8'h13; c_ld[3] = 8'h88;
      c_md[0] = 4'hF;  c_md[1] = 4'h0;  c_md[2] = 4'h0;  c_md[3] = 4'h3;
      c_pr = 4'b1011;
      sweep();

      // table B: all present, mixed flat and cluster models
      c_id[0] = 8'h00; c_id[1] = 8'h31; c_id[2] = 8'h54; c_id[3] = 8'hFE;
      c_ld[0] = 8'h21; c_ld[1] = 8'h80; c_ld[2] = 8'h23; c_ld[3] = 8'h06;
      c_md[0] = 4'h0;  c_md[1] = 4'hF;  c_md[2] = 4'h0;  c_md[3] = 4'hF;
      c_pr = 4'b1111;
      sweep();

      @(negedge clk);
      check(!done && dlv_mask == '0, "R10 final idle", {done, dlv_mask}, '0);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule